// File: doc/BRIEF.md
# Predicate Compare and Bit-Test Unit

This unit takes up to a parameterised number of compare requests in the same cycle. It turns each request into writes to a small file of 1-bit predicates. A request does one of two things:

- It compares two 64-bit operands under a signed or unsigned relation. The left operand can be an 8-bit immediate, which is sign-extended.
- It tests one bit of its right operand. The test can ask whether that bit is zero or whether it is nonzero.

The boolean outcome is then mapped onto two destination predicates, named `t` and `f`, according to a compare type. A normal compare always writes the outcome and its complement. Six wired types write fixed values to both destinations on only one outcome, and leave both destinations alone on the other outcome. Because of this, several wired writers in one group can safely target the same predicate and build an OR or AND of their conditions.

The unit merges all writers of a cycle and detects conflicting writes. It rejects operand and relation combinations that the wired types do not allow. It reports conflicts and rejected requests one cycle later, together with the predicate update.

Top module: `pred_cmp_unit`

## Requirements
- R1: The relation code on `req_crel` selects the compare as follows:
  - 0: equal
  - 1: not equal
  - 2: signed less-than
  - 3: signed less-or-equal
  - 4: signed greater-than
  - 5: signed greater-or-equal
  - 6: unsigned less-than
  - 7: unsigned greater-or-equal

  The compare is `A rel B`. A is `req_a`, or the sign-extended `req_imm` when `req_use_imm` is 1. B is `req_b`.
- R2: With `req_is_tbit`=1, the lane tests bit `req_pos` of `req_b`. With relation 1 (nonzero sense), the outcome is true when that bit is 1. With relation 0 (zero sense), the outcome is true when that bit is 0.
- R3: Type code 0 (normal) writes `t`=outcome and `f`=not outcome.
- R4: Type code 1 writes `t`=1 and `f`=1 on a true outcome. Type code 2 writes `t`=0 and `f`=0 on a false outcome. On the other outcome, each of these types leaves both predicates unchanged.
- R5: Type code 3 writes `t`=1 and `f`=0 on a true outcome. Type code 4 writes `t`=1 and `f`=1 on a false outcome. On the other outcome, each leaves both predicates unchanged.
- R6: Type code 5 writes `t`=0 and `f`=0 on a true outcome. Type code 6 writes `t`=0 and `f`=1 on a false outcome. On the other outcome, each leaves both predicates unchanged.
- R7: A valid lane is illegal, writes nothing and sets its bit of `illegal_q` on the next cycle when any of the following holds:
  - It uses type code 7.
  - It is a bit test with a relation other than 0 or 1.
  - It is a wired compare (type 1 to 6) with relation 6 or 7.
  - It is a wired compare with relation 2 to 5 and `req_use_imm`=1.

  A legal wired compare with relation 2 to 5 uses zero as A, whatever the value of `req_a`.
- R8: Several lanes may write the same value to the same predicate in one cycle without a conflict.
- R9: `conflict_q` rises on the next cycle, and no predicate changes at that edge, in either of these cases:
  - Two writes in one cycle give one nonzero predicate different values.
  - A legal normal lane names a nonzero predicate that any other legal valid lane names as `t` or `f`.
- R10: Predicate 0 always reads 1. Writes to it are dropped and never cause a conflict.
- R11: Updates take effect at the next rising clock edge. Reset sets `pred_q` to 1 (only predicate 0 set) and clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | N | Lane request valid |
| req_is_tbit | input | N | Lane performs a bit test instead of a compare |
| req_use_imm | input | N | Replace A with the sign-extended immediate |
| req_ctype | input | 3*N | Compare type code per lane |
| req_crel | input | 3*N | Relation code per lane |
| req_imm | input | 8*N | 8-bit immediate per lane |
| req_a | input | 64*N | Operand A per lane |
| req_b | input | 64*N | Operand B per lane, also the bit-test source |
| req_pos | input | 6*N | Bit position for the bit test |
| req_pt | input | 6*N | Destination index for `t` |
| req_pf | input | 6*N | Destination index for `f` |
| pred_q | output | 64 | Predicate file contents |
| illegal_q | output | N | Per-lane illegal flag for the previous cycle |
| conflict_q | output | 1 | Write conflict in the previous cycle |

## Verification
Every result of this block is due exactly one rising edge after the request is presented. This covers the predicate bits, the per-lane illegal flags and the conflict flag, which all come from registers loaded at the same edge. The bench changes requests 1 ns after an edge, so the inputs are stable well before the next edge. It computes the expected predicate file from its own model before that edge, and compares all three outputs 1 ns after it. Nothing is sampled at an edge, and no result is expected to take any other latency.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    CT_NORMAL   = 3'd0,
    CT_OR       = 3'd1,
    CT_AND      = 3'd2,
    CT_OR_ANDCM = 3'd3,
    CT_ORCM     = 3'd4,
    CT_ANDCM    = 3'd5,
    CT_AND_ORCM = 3'd6,
    CT_RSVD     = 3'd7
  } ctype_e;

  typedef enum logic [2:0] {
    CR_EQ  = 3'd0,
    CR_NE  = 3'd1,
    CR_LT  = 3'd2,
    CR_LE  = 3'd3,
    CR_GT  = 3'd4,
    CR_GE  = 3'd5,
    CR_LTU = 3'd6,
    CR_GEU = 3'd7
  } crel_e;

  typedef struct packed {
    logic en;
    logic val;
  } pwr_t;

  typedef struct packed {
    pwr_t t;
    pwr_t f;
  } pact_t;

  // Map a compare type and its outcome to the two predicate writes.
  function automatic pact_t pred_action(ctype_e ct, logic outcome);
    pact_t r;
    r = '0;
    unique case (ct)
      CT_NORMAL: begin
        r.t = '{1'b1, outcome};
        r.f = '{1'b1, !outcome};
      end
      CT_OR:       if (outcome)  r = '{'{1'b1, 1'b1}, '{1'b1, 1'b1}};
      CT_AND:      if (!outcome) r = '{'{1'b1, 1'b0}, '{1'b1, 1'b0}};
      CT_OR_ANDCM: if (outcome)  r = '{'{1'b1, 1'b1}, '{1'b1, 1'b0}};
      CT_ORCM:     if (!outcome) r = '{'{1'b1, 1'b1}, '{1'b1, 1'b1}};
      CT_ANDCM:    if (outcome)  r = '{'{1'b1, 1'b0}, '{1'b1, 1'b0}};
      CT_AND_ORCM: if (!outcome) r = '{'{1'b1, 1'b0}, '{1'b1, 1'b1}};
      default:     r = '0;
    endcase
    return r;
  endfunction

  function automatic logic is_signed_ineq(crel_e r);
    return (r == CR_LT) || (r == CR_LE) || (r == CR_GT) || (r == CR_GE);
  endfunction

  function automatic logic is_unsigned_rel(crel_e r);
    return (r == CR_LTU) || (r == CR_GEU);
  endfunction

endpackage

// File: rtl/pcu_lane_eval.sv
module pcu_lane_eval
  import pcu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8,
  localparam int POSW  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              is_tbit,
  input  logic              use_imm,
  input  logic [2:0]        ctype,
  input  logic [2:0]        crel,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [POSW-1:0]   pos,
  output logic              illegal,
  output logic              active,
  output logic              normal,
  output logic              t_en,
  output logic              t_val,
  output logic              f_en,
  output logic              f_val
);

  ctype_e ct;
  crel_e  cr;
  assign ct = ctype_e'(ctype);
  assign cr = crel_e'(crel);

  function automatic logic rel_holds(crel_e r, logic [DATA_W-1:0] x, logic [DATA_W-1:0] y);
    logic res;
    unique case (r)
      CR_EQ:   res = (x == y);
      CR_NE:   res = (x != y);
      CR_LT:   res = ($signed(x) <  $signed(y));
      CR_LE:   res = ($signed(x) <= $signed(y));
      CR_GT:   res = ($signed(x) >  $signed(y));
      CR_GE:   res = ($signed(x) >= $signed(y));
      CR_LTU:  res = (x <  y);
      default: res = (x >= y);
    endcase
    return res;
  endfunction

  // Named internal events for the assertions below.
  logic              parallel_type;
  logic              bad_rsvd;
  logic              bad_tbit_rel;
  logic              bad_par_unsigned;
  logic              bad_par_imm;
  logic              zero_left;
  logic [DATA_W-1:0] imm_sext;
  logic [DATA_W-1:0] left_op;
  logic              tested_bit;
  logic              lane_outcome;
  pact_t             act;

  assign parallel_type    = (ct != CT_NORMAL);
  assign bad_rsvd         = (ct == CT_RSVD);
  assign bad_tbit_rel     = is_tbit && (cr != CR_EQ) && (cr != CR_NE);
  assign bad_par_unsigned = !is_tbit && parallel_type && is_unsigned_rel(cr);
  assign bad_par_imm      = !is_tbit && parallel_type && is_signed_ineq(cr) && use_imm;

  assign illegal = valid && (bad_rsvd || bad_tbit_rel || bad_par_unsigned || bad_par_imm);
  assign active  = valid && !illegal;
  assign normal  = (ct == CT_NORMAL);

  assign zero_left = parallel_type && is_signed_ineq(cr);
  assign imm_sext  = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    if (zero_left)    left_op = '0;
    else if (use_imm) left_op = imm_sext;
    else              left_op = opa;
  end

  assign tested_bit   = opb[pos];
  assign lane_outcome = is_tbit ? (tested_bit ^ (cr == CR_EQ)) : rel_holds(cr, left_op, opb);

  assign act   = pred_action(ct, lane_outcome);
  assign t_en  = active && act.t.en;
  assign t_val = act.t.val;
  assign f_en  = active && act.f.en;
  assign f_val = act.f.val;

  // R7: a rejected request never produces a predicate write.
  assert_illegal_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!t_en && !f_en));

  // R3: a legal normal compare always writes a complementary pair.
  assert_normal_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && normal) |-> (t_en && f_en && (t_val != f_val)));

  // R4: wired types write both destinations or neither.
  assert_wired_both_or_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && parallel_type) |-> (t_en == f_en));

endmodule

// File: rtl/pcu_write_arb.sv
module pcu_write_arb #(
  parameter int N_LANES = 3,
  parameter int NPRED   = 64,
  localparam int PIW    = $clog2(NPRED)
) (
  input  logic [N_LANES-1:0]     lane_active,
  input  logic [N_LANES-1:0]     lane_normal,
  input  logic [N_LANES-1:0]     t_en,
  input  logic [N_LANES-1:0]     t_val,
  input  logic [N_LANES-1:0]     f_en,
  input  logic [N_LANES-1:0]     f_val,
  input  logic [N_LANES*PIW-1:0] pt_idx,
  input  logic [N_LANES*PIW-1:0] pf_idx,
  output logic [NPRED-1:0]       wr_mask,
  output logic [NPRED-1:0]       wr_data,
  output logic                   value_clash,
  output logic                   normal_share,
  output logic                   conflict
);

  logic [NPRED-1:0] set_v;
  logic [NPRED-1:0] clr_v;

  // Gather every write of the cycle into a set vector and a clear vector.
  always_comb begin
    set_v = '0;
    clr_v = '0;
    for (int i = 0; i < N_LANES; i++) begin
      if (t_en[i]) begin
        if (t_val[i]) set_v[pt_idx[i*PIW +: PIW]] = 1'b1;
        else          clr_v[pt_idx[i*PIW +: PIW]] = 1'b1;
      end
      if (f_en[i]) begin
        if (f_val[i]) set_v[pf_idx[i*PIW +: PIW]] = 1'b1;
        else          clr_v[pf_idx[i*PIW +: PIW]] = 1'b1;
      end
    end
    set_v[0] = 1'b0;
    clr_v[0] = 1'b0;
  end

  function automatic logic name_overlap(logic [PIW-1:0] a0, logic [PIW-1:0] a1,
                                        logic [PIW-1:0] b0, logic [PIW-1:0] b1);
    logic hit;
    hit = 1'b0;
    if ((a0 != '0) && ((a0 == b0) || (a0 == b1))) hit = 1'b1;
    if ((a1 != '0) && ((a1 == b0) || (a1 == b1))) hit = 1'b1;
    return hit;
  endfunction

  // A normal compare may not share any destination with another writer.
  always_comb begin
    normal_share = 1'b0;
    for (int i = 0; i < N_LANES; i++) begin
      for (int j = 0; j < N_LANES; j++) begin
        if ((i != j) && lane_active[i] && lane_normal[i] && lane_active[j] &&
            name_overlap(pt_idx[i*PIW +: PIW], pf_idx[i*PIW +: PIW],
                         pt_idx[j*PIW +: PIW], pf_idx[j*PIW +: PIW]))
          normal_share = 1'b1;
      end
    end
  end

  assign value_clash = |(set_v & clr_v);
  assign conflict    = value_clash || normal_share;
  assign wr_mask     = conflict ? '0 : (set_v | clr_v);
  assign wr_data     = set_v;

endmodule

// File: rtl/pcu_pred_file.sv
module pcu_pred_file #(
  parameter int NPRED = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPRED-1:0] wr_mask,
  input  logic [NPRED-1:0] wr_data,
  output logic [NPRED-1:0] pred
);

  for (genvar p = 0; p < NPRED; p++) begin : g_pred
    if (p == 0) begin : g_const
      assign pred[p] = 1'b1;
    end else begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pred[p] <= 1'b0;
        else if (wr_mask[p]) pred[p] <= wr_data[p];
      end
    end
  end

  // R10: the hardwired predicate never reads 0.
  assert_p0_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pred[0] == 1'b1);

endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
  import pcu_pkg::*;
#(
  parameter int N_LANES = 3,
  parameter int DATA_W  = 64,
  parameter int IMM_W   = 8,
  parameter int NPRED   = 64,
  localparam int PIW    = $clog2(NPRED),
  localparam int POSW   = $clog2(DATA_W)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LANES-1:0]        req_valid,
  input  logic [N_LANES-1:0]        req_is_tbit,
  input  logic [N_LANES-1:0]        req_use_imm,
  input  logic [N_LANES*3-1:0]      req_ctype,
  input  logic [N_LANES*3-1:0]      req_crel,
  input  logic [N_LANES*IMM_W-1:0]  req_imm,
  input  logic [N_LANES*DATA_W-1:0] req_a,
  input  logic [N_LANES*DATA_W-1:0] req_b,
  input  logic [N_LANES*POSW-1:0]   req_pos,
  input  logic [N_LANES*PIW-1:0]    req_pt,
  input  logic [N_LANES*PIW-1:0]    req_pf,
  output logic [NPRED-1:0]          pred_q,
  output logic [N_LANES-1:0]        illegal_q,
  output logic                      conflict_q
);

  logic [N_LANES-1:0] lane_illegal;
  logic [N_LANES-1:0] lane_active;
  logic [N_LANES-1:0] lane_normal;
  logic [N_LANES-1:0] t_en;
  logic [N_LANES-1:0] t_val;
  logic [N_LANES-1:0] f_en;
  logic [N_LANES-1:0] f_val;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    pcu_lane_eval #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_eval (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (req_valid[i]),
      .is_tbit (req_is_tbit[i]),
      .use_imm (req_use_imm[i]),
      .ctype   (req_ctype[i*3 +: 3]),
      .crel    (req_crel[i*3 +: 3]),
      .imm     (req_imm[i*IMM_W +: IMM_W]),
      .opa     (req_a[i*DATA_W +: DATA_W]),
      .opb     (req_b[i*DATA_W +: DATA_W]),
      .pos     (req_pos[i*POSW +: POSW]),
      .illegal (lane_illegal[i]),
      .active  (lane_active[i]),
      .normal  (lane_normal[i]),
      .t_en    (t_en[i]),
      .t_val   (t_val[i]),
      .f_en    (f_en[i]),
      .f_val   (f_val[i])
    );
  end

  logic [NPRED-1:0] wr_mask;
  logic [NPRED-1:0] wr_data;
  logic             value_clash;
  logic             normal_share;
  logic             conflict;

  pcu_write_arb #(.N_LANES(N_LANES), .NPRED(NPRED)) u_arb (
    .lane_active  (lane_active),
    .lane_normal  (lane_normal),
    .t_en         (t_en),
    .t_val        (t_val),
    .f_en         (f_en),
    .f_val        (f_val),
    .pt_idx       (req_pt),
    .pf_idx       (req_pf),
    .wr_mask      (wr_mask),
    .wr_data      (wr_data),
    .value_clash  (value_clash),
    .normal_share (normal_share),
    .conflict     (conflict)
  );

  pcu_pred_file #(.NPRED(NPRED)) u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mask (wr_mask),
    .wr_data (wr_data),
    .pred    (pred_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illegal_q  <= '0;
      conflict_q <= 1'b0;
    end else begin
      illegal_q  <= lane_illegal;
      conflict_q <= conflict;
    end
  end

  // R9: a cycle flagged as conflicting left every predicate as it was.
  assert_conflict_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_q |-> (pred_q == $past(pred_q)));

  // R9: the flag rises after a normal compare shares a destination.
  assert_share_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
    normal_share |=> conflict_q);

  // R7: rejected lanes are reported on the following cycle.
  assert_illegal_reported_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_illegal) |=> ((illegal_q & $past(lane_illegal)) == $past(lane_illegal)));

endmodule

// File: tb/tb_pred_cmp_unit.sv
module tb_pred_cmp_unit;

  localparam int NL = 3;
  localparam int DW = 64;
  localparam int NP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NL-1:0]    req_valid, req_is_tbit, req_use_imm;
  logic [NL*3-1:0]  req_ctype, req_crel;
  logic [NL*8-1:0]  req_imm;
  logic [NL*DW-1:0] req_a, req_b;
  logic [NL*6-1:0]  req_pos, req_pt, req_pf;
  logic [NP-1:0]    pred_q;
  logic [NL-1:0]    illegal_q;
  logic             conflict_q;

  pred_cmp_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_tbit(req_is_tbit),
    .req_use_imm(req_use_imm), .req_ctype(req_ctype), .req_crel(req_crel),
    .req_imm(req_imm), .req_a(req_a), .req_b(req_b), .req_pos(req_pos),
    .req_pt(req_pt), .req_pf(req_pf), .pred_q(pred_q), .illegal_q(illegal_q),
    .conflict_q(conflict_q)
  );

  bit         l_v[NL], l_tb[NL], l_ui[NL];
  logic [2:0] l_ct[NL], l_cr[NL];
  logic [7:0] l_imm[NL];
  logic [63:0] l_a[NL], l_b[NL];
  logic [5:0] l_pos[NL], l_pt[NL], l_pf[NL];

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      req_valid[i]         = l_v[i];
      req_is_tbit[i]       = l_tb[i];
      req_use_imm[i]       = l_ui[i];
      req_ctype[i*3 +: 3]  = l_ct[i];
      req_crel[i*3 +: 3]   = l_cr[i];
      req_imm[i*8 +: 8]    = l_imm[i];
      req_a[i*DW +: DW]    = l_a[i];
      req_b[i*DW +: DW]    = l_b[i];
      req_pos[i*6 +: 6]    = l_pos[i];
      req_pt[i*6 +: 6]     = l_pt[i];
      req_pf[i*6 +: 6]     = l_pf[i];
    end
  end

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [NP-1:0] pred_m;
  logic [NL-1:0] ill_m;
  bit            conf_m;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_lanes();
    for (int i = 0; i < NL; i++) begin
      l_v[i] = 0; l_tb[i] = 0; l_ui[i] = 0; l_ct[i] = 0; l_cr[i] = 0; l_imm[i] = 0;
      l_a[i] = 0; l_b[i] = 0; l_pos[i] = 0; l_pt[i] = 0; l_pf[i] = 0;
    end
  endtask

  task automatic set_lane(input int i, input bit tb, input bit ui, input logic [7:0] imm,
                          input logic [2:0] ct, input logic [2:0] cr, input logic [63:0] a,
                          input logic [63:0] b, input logic [5:0] pos, input logic [5:0] pt,
                          input logic [5:0] pf);
    l_v[i] = 1; l_tb[i] = tb; l_ui[i] = ui; l_imm[i] = imm; l_ct[i] = ct; l_cr[i] = cr;
    l_a[i] = a; l_b[i] = b; l_pos[i] = pos; l_pt[i] = pt; l_pf[i] = pf;
  endtask

  // Outcome as the requirements describe it (R1, R2, R7 zero-left rule).
  function automatic bit bench_outcome(int i);
    logic [63:0] lhs;
    bit b;
    if (l_tb[i]) begin
      b = l_b[i][l_pos[i]];
      return (l_cr[i] == 3'd1) ? b : !b;
    end
    if (l_ct[i] != 3'd0 && l_cr[i] >= 3'd2 && l_cr[i] <= 3'd5) lhs = 64'd0;
    else if (l_ui[i]) lhs = {{56{l_imm[i][7]}}, l_imm[i]};
    else lhs = l_a[i];
    case (l_cr[i])
      3'd0: return lhs == l_b[i];
      3'd1: return lhs != l_b[i];
      3'd2: return $signed(lhs) < $signed(l_b[i]);
      3'd3: return !($signed(l_b[i]) < $signed(lhs));
      3'd4: return $signed(l_b[i]) < $signed(lhs);
      3'd5: return !($signed(lhs) < $signed(l_b[i]));
      3'd6: return lhs < l_b[i];
      default: return !(lhs < l_b[i]);
    endcase
  endfunction

  // Next state of the predicate file computed before the edge.
  task automatic model_step();
    bit act[NL];
    bit s1[NP], s0[NP];
    bit share;
    bit o, dt, vt, df, vf;
    for (int p = 0; p < NP; p++) begin s1[p] = 0; s0[p] = 0; end
    share = 0;
    for (int i = 0; i < NL; i++) begin
      bit bad;
      bad = (l_ct[i] == 3'd7) || (l_tb[i] && l_cr[i] > 3'd1) ||
            (!l_tb[i] && l_ct[i] != 3'd0 && l_cr[i] >= 3'd6) ||
            (!l_tb[i] && l_ct[i] != 3'd0 && l_cr[i] >= 3'd2 && l_cr[i] <= 3'd5 && l_ui[i]);
      ill_m[i] = l_v[i] && bad;
      act[i] = l_v[i] && !bad;
    end
    for (int i = 0; i < NL; i++) begin
      if (!act[i]) continue;
      o = bench_outcome(i);
      {dt, vt, df, vf} = 4'b0000;
      case (l_ct[i])
        3'd0: {dt, vt, df, vf} = {1'b1, o, 1'b1, !o};
        3'd1: if (o)  {dt, vt, df, vf} = 4'b1111;
        3'd2: if (!o) {dt, vt, df, vf} = 4'b1010;
        3'd3: if (o)  {dt, vt, df, vf} = 4'b1110;
        3'd4: if (!o) {dt, vt, df, vf} = 4'b1111;
        3'd5: if (o)  {dt, vt, df, vf} = 4'b1010;
        3'd6: if (!o) {dt, vt, df, vf} = 4'b1011;
        default: ;
      endcase
      if (dt && l_pt[i] != 0) begin if (vt) s1[l_pt[i]] = 1; else s0[l_pt[i]] = 1; end
      if (df && l_pf[i] != 0) begin if (vf) s1[l_pf[i]] = 1; else s0[l_pf[i]] = 1; end
      if (l_ct[i] == 3'd0) begin
        for (int j = 0; j < NL; j++) begin
          if (j == i || !act[j]) continue;
          if ((l_pt[i] != 0 && (l_pt[i] == l_pt[j] || l_pt[i] == l_pf[j])) ||
              (l_pf[i] != 0 && (l_pf[i] == l_pt[j] || l_pf[i] == l_pf[j])))
            share = 1;
        end
      end
    end
    conf_m = share;
    for (int p = 1; p < NP; p++) if (s1[p] && s0[p]) conf_m = 1;
    if (!conf_m)
      for (int p = 1; p < NP; p++) begin
        if (s1[p]) pred_m[p] = 1'b1;
        else if (s0[p]) pred_m[p] = 1'b0;
      end
    pred_m[0] = 1'b1;
  endtask

  task automatic step(input string tag);
    model_step();
    @(posedge clk);
    #1;
    check(pred_q === pred_m, {tag, " R11 predicate file"}, pred_q, pred_m);
    check(illegal_q === ill_m, {tag, " R7 illegal flags"}, {61'd0, illegal_q}, {61'd0, ill_m});
    check(conflict_q === conf_m, {tag, " R9 conflict flag"}, {63'd0, conflict_q}, {63'd0, conf_m});
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    clear_lanes();
    pred_m = 64'd1;
    ill_m = '0;
    conf_m = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    check(pred_q === 64'd1, "R11 reset predicates", pred_q, 64'd1);
    check(illegal_q === '0 && conflict_q === 1'b0, "R11 reset flags", {62'd0, illegal_q[1:0]}, 64'd0);

    // R1: immediate sign extension, unsigned and signed relations
    clear_lanes();
    set_lane(0, 0, 1, 8'hA5, 3'd0, 3'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFA5, 6'd0, 6'd1, 6'd2);
    set_lane(1, 0, 0, 8'h00, 3'd0, 3'd6, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, 6'd3, 6'd4);
    set_lane(2, 0, 0, 8'h00, 3'd0, 3'd2, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, 6'd5, 6'd6);
    step("dir-R1");
    check(pred_q[2:1] === 2'b01, "R1 imm sext eq", pred_q[2:1], 2'b01);
    check(pred_q[4:3] === 2'b01, "R1 unsigned lt", pred_q[4:3], 2'b01);
    check(pred_q[6:5] === 2'b10, "R3 signed lt false", pred_q[6:5], 2'b10);

    // R2: bit test senses
    clear_lanes();
    set_lane(0, 1, 0, 8'h00, 3'd0, 3'd1, 64'd0, 64'h8000_0000_0000_0000, 6'd63, 6'd7, 6'd8);
    set_lane(1, 1, 0, 8'h00, 3'd0, 3'd0, 64'd0, 64'h20, 6'd5, 6'd9, 6'd10);
    step("dir-R2");
    check(pred_q[8:7] === 2'b01, "R2 nz bit63", pred_q[8:7], 2'b01);
    check(pred_q[10:9] === 2'b10, "R2 z bit5 set", pred_q[10:9], 2'b10);

    // R4: or then and then or-false
    clear_lanes();
    set_lane(0, 0, 0, 8'h00, 3'd1, 3'd0, 64'd9, 64'd9, 6'd0, 6'd11, 6'd12);
    step("dir-R4a");
    check(pred_q[12:11] === 2'b11, "R4 or true", pred_q[12:11], 2'b11);
    clear_lanes();
    set_lane(0, 0, 0, 8'h00, 3'd2, 3'd0, 64'd9, 64'd8, 6'd0, 6'd11, 6'd12);
    step("dir-R4b");
    check(pred_q[12:11] === 2'b00, "R4 and false", pred_q[12:11], 2'b00);
    clear_lanes();
    set_lane(0, 0, 0, 8'h00, 3'd1, 3'd0, 64'd9, 64'd8, 6'd0, 6'd11, 6'd12);
    step("dir-R4c");
    check(pred_q[12:11] === 2'b00, "R4 or false unchanged", pred_q[12:11], 2'b00);

    // R5: or.andcm true, orcm true (no write), orcm false
    clear_lanes();
    set_lane(0, 0, 0, 8'h00, 3'd3, 3'd1, 64'd1, 64'd2, 6'd0, 6'd13, 6'd14);
    set_lane(1, 0, 0, 8'h00, 3'd4, 3'd1, 64'd1, 64'd2, 6'd0, 6'd15, 6'd16);
    step("dir-R5a");
    check(pred_q[14:13] === 2'b01, "R5 or.andcm true", pred_q[14:13], 2'b01);
    check(pred_q[16:15] === 2'b00, "R5 orcm true unchanged", pred_q[16:15], 2'b00);
    clear_lanes();
    set_lane(0, 0, 0, 8'h00, 3'd4, 3'd1, 64'd2, 64'd2, 6'd0, 6'd15, 6'd16);
    step("dir-R5b");
    check(pred_q[16:15] === 2'b11, "R5 orcm false", pred_q[16:15], 2'b11);

    // R6: andcm true, and.orcm false
    clear_lanes();
    set_lane(0, 0, 0, 8'h00, 3'd5, 3'd0, 64'd4, 64'd4, 6'd0, 6'd15, 6'd16);
    set_lane(1, 0, 0, 8'h00, 3'd6, 3'd0, 64'd4, 64'd5, 6'd0, 6'd17, 6'd18);
    step("dir-R6");
    check(pred_q[16:15] === 2'b00, "R6 andcm true", pred_q[16:15], 2'b00);
    check(pred_q[18:17] === 2'b10, "R6 and.orcm false", pred_q[18:17], 2'b10);

    // R7: illegal combinations and the zero-left rule
    clear_lanes();
    set_lane(0, 0, 0, 8'h00, 3'd1, 3'd6, 64'd0, 64'd5, 6'd0, 6'd19, 6'd20);
    set_lane(1, 0, 1, 8'h01, 3'd1, 3'd2, 64'd0, 64'd5, 6'd0, 6'd19, 6'd20);
    set_lane(2, 0, 0, 8'h00, 3'd1, 3'd2, 64'd50, 64'd7, 6'd0, 6'd21, 6'd22);
    step("dir-R7");
    check(illegal_q === 3'b011, "R7 illegal lanes", {61'd0, illegal_q}, 64'd3);
    check(pred_q[20:19] === 2'b00, "R7 illegal no write", pred_q[20:19], 2'b00);
    check(pred_q[22:21] === 2'b11, "R7 zero-left lt", pred_q[22:21], 2'b11);

    // R8: three wired writers agreeing
    clear_lanes();
    for (int i = 0; i < NL; i++)
      set_lane(i, 0, 0, 8'h00, 3'd1, 3'd0, 64'd3, 64'd3, 6'd0, 6'd23, 6'd24);
    step("dir-R8");
    check(conflict_q === 1'b0 && pred_q[24:23] === 2'b11, "R8 shared wired or",
          {62'd0, pred_q[24:23]}, 64'd3);

    // R9: value clash, then normal sharing
    clear_lanes();
    set_lane(0, 0, 0, 8'h00, 3'd1, 3'd0, 64'd1, 64'd1, 6'd0, 6'd25, 6'd0);
    set_lane(1, 0, 0, 8'h00, 3'd2, 3'd0, 64'd1, 64'd2, 6'd0, 6'd25, 6'd0);
    set_lane(2, 0, 0, 8'h00, 3'd1, 3'd0, 64'd1, 64'd1, 6'd0, 6'd26, 6'd0);
    step("dir-R9a");
    check(conflict_q === 1'b1, "R9 value clash flag", {63'd0, conflict_q}, 64'd1);
    check(pred_q[26:25] === 2'b00, "R9 clash freezes file", pred_q[26:25], 2'b00);
    clear_lanes();
    set_lane(0, 0, 0, 8'h00, 3'd0, 3'd0, 64'd1, 64'd1, 6'd0, 6'd27, 6'd28);
    set_lane(1, 0, 0, 8'h00, 3'd1, 3'd0, 64'd1, 64'd2, 6'd0, 6'd28, 6'd29);
    step("dir-R9b");
    check(conflict_q === 1'b1 && pred_q[27] === 1'b0, "R9 normal share",
          {62'd0, conflict_q, pred_q[27]}, 64'd2);

    // R10: writes to predicate 0 dropped, no conflict from it
    clear_lanes();
    set_lane(0, 0, 0, 8'h00, 3'd0, 3'd0, 64'd1, 64'd2, 6'd0, 6'd0, 6'd30);
    set_lane(1, 0, 0, 8'h00, 3'd1, 3'd0, 64'd1, 64'd1, 6'd0, 6'd0, 6'd0);
    set_lane(2, 0, 0, 8'h00, 3'd2, 3'd0, 64'd1, 64'd2, 6'd0, 6'd0, 6'd0);
    step("dir-R10");
    check(pred_q[0] === 1'b1 && pred_q[30] === 1'b1 && conflict_q === 1'b0, "R10 p0 writes",
          {61'd0, pred_q[0], pred_q[30], conflict_q}, 64'd6);

    // Random mix, all requirements via the model (R1 R2 R3 R4 R5 R6 R7 R8 R9 R10)
    for (int k = 0; k < 400; k++) begin
      clear_lanes();
      for (int i = 0; i < NL; i++) begin
        logic [63:0] ra, rb;
        ra = {$urandom, $urandom};
        if ($urandom % 4 == 0) ra = {{56{ra[7]}}, ra[7:0]};
        rb = ($urandom % 3 == 0) ? ra : {$urandom, $urandom};
        if ($urandom % 4 == 0) rb = ~rb + 64'd1;
        l_v[i]   = ($urandom % 4) != 0;
        l_tb[i]  = ($urandom % 4) == 0;
        l_ui[i]  = ($urandom % 3) == 0;
        l_imm[i] = 8'($urandom);
        l_ct[i]  = 3'($urandom % 8);
        l_cr[i]  = (l_tb[i] && ($urandom % 4 != 0)) ? 3'($urandom % 2) : 3'($urandom % 8);
        l_a[i]   = ra;
        l_b[i]   = rb;
        l_pos[i] = 6'($urandom);
        l_pt[i]  = ($urandom % 8 == 0) ? 6'($urandom) : 6'($urandom % 8);
        l_pf[i]  = ($urandom % 8 == 0) ? 6'($urandom) : 6'($urandom % 8);
      end
      step("rand R8 R10");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule